// File: doc/BRIEF.md
# Successive Approximation ADC Controller

This block runs a 5-bit successive-approximation conversion on one of two pins that can serve either as digital inputs or as analog inputs. A mode register holds one bit per pin and picks the role of each pin. While a pin is in analog mode its digital read path is gated off, so any digital read of that pin returns 0.

A control write with two particular bits both set starts a conversion on the pin that the write selects. The controller then drives a trial code to an external DAC and reads back a comparator decision. It tests one bit per trial, starting at the most significant bit. After the last trial it latches the code and raises a completion flag. That flag stays set until a result read clears it. The comparator and the DAC are outside the block.

With a 75 kHz clock a conversion takes 96 cycles, which is 1.28 ms. Each of the five trials lasts 19 cycles, and one more cycle latches the result.

Top module: `sar_adc_ctrl`

## Requirements
- R1: The conversion is a binary search over 5 bits. A trial bit is kept when `cmp_ge` is 1, meaning the input is at or above `dac_code`. With an ideal comparator, an input level v gives the result min(v, 31).
- R2: `busy` stays high for exactly 96 clock cycles per conversion. `done` rises on the same edge at which `busy` falls.
- R3: A conversion starts only on a `ctl_we` write with both `ctl_wdata[3]` and `ctl_wdata[2]` set to 1. A write that lacks either bit does not start one.
- R4: When the conversion finishes, `done` is set and `result` holds the new code until the next conversion completes.
- R5: The mode register has one bit per pin, with 1 for analog and 0 for digital. A `mode_we` write loads it from `mode_wdata`.
- R6: `pin_rd[i]` follows `pin_din[i]` when pin i is in digital mode and reads 0 when the pin is in analog mode.
- R7: After reset, every pin is in digital mode, and `busy`, `done`, `result` and `dac_code` are all 0.
- R8: A `rd_result` pulse clears `done` on the next edge and leaves `result` unchanged. If completion happens on that same edge, the set wins.
- R9: A start write that arrives while `busy` is high is ignored. The running conversion keeps its channel, its length and its result.
- R10: `ctl_wdata[0]` chooses the pin to convert. `ana_sel` holds that choice for the whole conversion.
- R11: The first trial code is 5'b10000. Trials then move from the most significant bit to the least significant bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock (75 kHz nominal) |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_we | input | 1 | Write strobe for the pin mode register |
| mode_wdata | input | 2 | New pin modes, 1 = analog |
| pin_din | input | 2 | Digital levels seen at the shared pins |
| pin_rd | output | 2 | Gated digital read of the pins |
| ctl_we | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 4 | Control word: bits 3 and 2 start, bit 0 picks the channel |
| rd_result | input | 1 | Result read strobe, clears the done flag |
| cmp_ge | input | 1 | Comparator: the analog input is at or above the DAC level |
| dac_code | output | 5 | Trial code sent to the DAC, 0 when idle |
| ana_sel | output | 1 | Channel routed to the comparator |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | Completion flag |
| result | output | 5 | Last converted code |

## Verification
The assertions assume that `cmp_ge` is a function of the current `dac_code` and the selected channel's level. They also assume that strobes are single-cycle writes, sampled only at clock edges. The bench models the comparator as a combinational compare of a fixed integer level per channel against `dac_code`, and it holds that level steady for the whole conversion. All strobes are driven on falling edges and last one cycle. A start is issued mid-conversion only to check that it is ignored.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
  localparam int ADC_BITS = 5;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_TRIAL = 2'd1,
    S_LATCH = 2'd2
  } sar_state_e;

  // first trial code: only the top bit set
  function automatic logic [ADC_BITS-1:0] sar_seed();
    logic [ADC_BITS-1:0] c;
    c = '0;
    c[ADC_BITS-1] = 1'b1;
    return c;
  endfunction

  // resolve bit idx with the comparator decision, then raise the next lower bit
  function automatic logic [ADC_BITS-1:0] sar_step(
    input logic [ADC_BITS-1:0] code,
    input int unsigned         idx,
    input logic                keep
  );
    logic [ADC_BITS-1:0] c;
    c = code;
    if (!keep) c[idx] = 1'b0;
    if (idx > 0) c[idx-1] = 1'b1;
    return c;
  endfunction
endpackage

// File: rtl/sar_pin_mode.sv
module sar_pin_mode #(
  parameter int NPINS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_we,
  input  logic [NPINS-1:0] mode_wdata,
  input  logic [NPINS-1:0] pin_din,
  output logic [NPINS-1:0] pin_rd,
  output logic [NPINS-1:0] mode_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_we) mode_q <= mode_wdata;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_gate
    assign pin_rd[i] = pin_din[i] & ~mode_q[i];

    AST_ANALOG_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      mode_we && mode_wdata[i] |=> !pin_rd[i]); // R6
  end
endmodule

// File: rtl/sar_start_decode.sv
module sar_start_decode #(
  parameter int CHW = 1
) (
  input  logic           ctl_we,
  input  logic [3:0]     ctl_wdata,
  output logic           start_req,
  output logic [CHW-1:0] start_chan
);
  assign start_req  = ctl_we & ctl_wdata[3] & ctl_wdata[2];
  assign start_chan = ctl_wdata[CHW-1:0];
endmodule

// File: rtl/sar_engine.sv
module sar_engine
  import sar_adc_pkg::*;
#(
  parameter int RES       = ADC_BITS,
  parameter int TRIAL_CYC = 19,
  parameter int CHW       = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_req,
  input  logic [CHW-1:0] start_chan,
  input  logic           cmp_ge,
  input  logic           rd_result,
  output logic [RES-1:0] dac_code,
  output logic [CHW-1:0] chan_q,
  output logic           busy,
  output logic           done,
  output logic [RES-1:0] result
);
  localparam int CW    = (TRIAL_CYC > 1) ? $clog2(TRIAL_CYC) : 1;
  localparam int IW    = (RES > 1) ? $clog2(RES) : 1;
  localparam int TOTAL = RES * TRIAL_CYC + 1;
  localparam int LW    = $clog2(TOTAL + 2);

  sar_state_e      state;
  logic [CW-1:0]   cnt;
  logic [IW-1:0]   idx;
  logic [RES-1:0]  sar;
  logic            trial_end;
  logic            latch_evt;
  logic            accept;

  assign trial_end = (state == S_TRIAL) && (cnt == CW'(TRIAL_CYC - 1));
  assign latch_evt = (state == S_LATCH);
  assign accept    = (state == S_IDLE) && start_req;
  assign busy      = (state != S_IDLE);
  assign dac_code  = sar;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      idx    <= '0;
      sar    <= '0;
      chan_q <= '0;
      result <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          state  <= S_TRIAL;
          cnt    <= '0;
          idx    <= IW'(RES - 1);
          sar    <= sar_seed();
          chan_q <= start_chan;
        end
        S_TRIAL: if (trial_end) begin
          cnt <= '0;
          sar <= sar_step(sar, int'(idx), cmp_ge);
          if (idx == '0) state <= S_LATCH;
          else           idx   <= idx - 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_LATCH: begin
          result <= sar;
          sar    <= '0;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         done <= 1'b0;
    else if (latch_evt) done <= 1'b1;
    else if (rd_result) done <= 1'b0;
  end

  // cycle counter for the length check only
  logic [LW-1:0] len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= '0;
    else if (accept) len_q <= '0;
    else if (busy)   len_q <= len_q + 1'b1;
  end

  AST_CONV_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> len_q == LW'(TOTAL)); // R2
  AST_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> dac_code == sar_seed()); // R11
  AST_DONE_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    latch_evt |=> done && !busy); // R4
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_result && !latch_evt |=> !done && $stable(result)); // R8
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start_req && !trial_end |=> $stable(idx) && $stable(chan_q)); // R9
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_adc_pkg::*;
#(
  parameter int NPINS     = 2,
  parameter int RES       = ADC_BITS,
  parameter int TRIAL_CYC = 19,
  localparam int CHW      = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_we,
  input  logic [NPINS-1:0] mode_wdata,
  input  logic [NPINS-1:0] pin_din,
  output logic [NPINS-1:0] pin_rd,
  input  logic             ctl_we,
  input  logic [3:0]       ctl_wdata,
  input  logic             rd_result,
  input  logic             cmp_ge,
  output logic [RES-1:0]   dac_code,
  output logic [CHW-1:0]   ana_sel,
  output logic             busy,
  output logic             done,
  output logic [RES-1:0]   result
);
  logic [NPINS-1:0] mode_q;
  logic             start_req;
  logic [CHW-1:0]   start_chan;

  sar_pin_mode #(.NPINS(NPINS)) u_mode (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .pin_din(pin_din), .pin_rd(pin_rd), .mode_q(mode_q)
  );

  sar_start_decode #(.CHW(CHW)) u_dec (
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .start_req(start_req), .start_chan(start_chan)
  );

  sar_engine #(.RES(RES), .TRIAL_CYC(TRIAL_CYC), .CHW(CHW)) u_eng (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .start_chan(start_chan),
    .cmp_ge(cmp_ge), .rd_result(rd_result), .dac_code(dac_code),
    .chan_q(ana_sel), .busy(busy), .done(done), .result(result)
  );

  AST_START_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !(ctl_we && ctl_wdata[3] && ctl_wdata[2]) |=> !busy); // R3
endmodule

// File: tb/sar_adc_ctrl_tb.sv
module sar_adc_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CONV_LEN   = 96;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_we = 1'b0;
  logic [1:0] mode_wdata = '0;
  logic [1:0] pin_din = '0;
  logic [1:0] pin_rd;
  logic       ctl_we = 1'b0;
  logic [3:0] ctl_wdata = '0;
  logic       rd_result = 1'b0;
  logic       cmp_ge;
  logic [4:0] dac_code;
  logic [0:0] ana_sel;
  logic       busy, done;
  logic [4:0] result;

  int vin [2];
  int n_chk = 0, n_bad = 0;
  int exp_q[$];
  int chq[$];
  int exp_ch = 0;
  int blen = 0;
  logic prev_busy = 1'b0, prev_done = 1'b0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // comparator model: analog level of the selected pin against the DAC code
  always_comb cmp_ge = (vin[ana_sel] >= int'(dac_code));

  sar_adc_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .pin_din(pin_din), .pin_rd(pin_rd), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .rd_result(rd_result), .cmp_ge(cmp_ge), .dac_code(dac_code),
    .ana_sel(ana_sel), .busy(busy), .done(done), .result(result)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor: pops expected codes when done rises
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) begin
        if (!prev_busy) begin
          blen = 0;
          chk(dac_code == 5'b10000, "R11 first trial", dac_code, 16);
        end
        blen++;
        if (int'(ana_sel) != exp_ch) chk(0, "R10 channel held", ana_sel, exp_ch);
      end
      if (done && !prev_done) begin
        if (exp_q.size() == 0) chk(0, "R4 unexpected done", 1, 0);
        else begin
          int e, c;
          e = exp_q.pop_front();
          c = chq.pop_front();
          chk(int'(result) == e, "R1 R4 result", result, e);
          chk(blen == CONV_LEN, "R2 busy length", blen, CONV_LEN);
          chk(!busy, "R2 busy low at done", busy, 0);
          chk(c == exp_ch, "R10 channel", c, exp_ch);
        end
      end
    end
    prev_busy = busy;
    prev_done = done;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_mode(input logic [1:0] m);
    mode_we = 1'b1; mode_wdata = m;
    tick(1);
    mode_we = 1'b0;
  endtask

  task automatic write_ctl(input logic [3:0] w);
    ctl_we = 1'b1; ctl_wdata = w;
    tick(1);
    ctl_we = 1'b0; ctl_wdata = '0;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 300 && !done; k++) tick(1);
  endtask

  task automatic read_back(input int e);
    rd_result = 1'b1;
    tick(1);
    rd_result = 1'b0;
    chk(!done, "R8 done cleared", done, 0);
    chk(int'(result) == e, "R8 result kept", result, e);
  endtask

  task automatic convert(input int ch, input int v);
    int e;
    e = (v > 31) ? 31 : v;
    vin[ch] = v;
    exp_ch = ch;
    exp_q.push_back(e);
    chq.push_back(ch);
    write_ctl(4'b1100 | 4'(ch));
    wait_done();
    tick(1);
    read_back(e);
  endtask

  initial begin
    vin[0] = 0; vin[1] = 0;
    tick(3);
    chk(pin_rd == 2'b00 && busy == 0 && done == 0, "R7 reset outputs", {busy, done}, 0);
    pin_din = 2'b11;
    tick(1);
    chk(pin_rd == 2'b11, "R7 pins digital after reset", pin_rd, 3);
    rst_n = 1'b1;
    tick(1);
    chk(result == 0 && dac_code == 0, "R7 result and dac zero", result, 0);

    write_mode(2'b01);
    chk(pin_rd == 2'b10, "R5 R6 pin0 analog", pin_rd, 2);
    write_mode(2'b10);
    chk(pin_rd == 2'b01, "R5 R6 pin1 analog", pin_rd, 1);
    write_mode(2'b11);
    chk(pin_rd == 2'b00, "R6 both analog", pin_rd, 0);
    pin_din = 2'b10;
    write_mode(2'b00);
    chk(pin_rd == 2'b10, "R6 digital follows pin", pin_rd, 2);
    write_mode(2'b11);

    // writes lacking a start bit
    write_ctl(4'b1000); tick(2);
    chk(!busy, "R3 bit3 only", busy, 0);
    write_ctl(4'b0100); tick(2);
    chk(!busy, "R3 bit2 only", busy, 0);
    write_ctl(4'b0011); tick(2);
    chk(!busy, "R3 neither", busy, 0);

    convert(0, 0);
    convert(1, 31);
    convert(0, 21);
    convert(1, 10);
    convert(0, 40);
    convert(1, 16);
    convert(0, 15);

    // start while busy is ignored
    vin[0] = 7; vin[1] = 25;
    exp_ch = 0;
    exp_q.push_back(7);
    chq.push_back(0);
    write_ctl(4'b1100);
    tick(30);
    write_ctl(4'b1101);
    wait_done();
    tick(1);
    read_back(7);
    tick(3);
    chk(!busy, "R9 no restart after ignored start", busy, 0);
    chk(exp_q.size() == 0, "R9 no extra result", exp_q.size(), 0);

    // read on idle keeps result
    read_back(7);

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule